// File: doc/BRIEF.md
# Storage-Key Memory Protection Checker

This block guards a partitioned physical memory by tagging every fixed-size block with a small protection key. A host loads the key of each block through a write port, and a separate register holds the key of the partition that is running. Every memory reference is presented as an address, a privilege flag and a valid strobe. The checker derives the block number from the upper address bits and looks up that block's key. It compares this key with the running key and answers one cycle later with either a grant or a protection violation.

All blocks owned by one partition carry the same key, so partitions are whole multiples of a block. With the default parameters, 64 KB is split into thirty-two 2 KB blocks, each with a 4-bit key, which allows sixteen distinct partitions. Privileged references bypass the key comparison. Allocation policy, the software that picks the keys and the memory array itself sit outside this block.

Top module: `key_prot_chk`

## Requirements
- R1: After reset both outputs are low, every block key is 0 and the running key is 0, so an unprivileged reference to any block is granted until keys change.
- R2: The block number is address bits [15:11] (block size 2 KB, 32 blocks); bits [10:0] have no effect on the decision.
- R3: An unprivileged valid reference whose block key equals the running key raises grant_o (and only grant_o) in the cycle after the request.
- R4: An unprivileged valid reference whose block key differs from the running key raises viol_o (and only viol_o) in the cycle after the request.
- R5: A valid reference with req_priv_i high is granted whatever the keys are.
- R6: In the cycle after a cycle with req_valid_i low, grant_o and viol_o are both low.
- R7: grant_o and viol_o are never high together, and exactly one of them is high after each valid request.
- R8: A key written at a clock edge is used by requests sampled at later edges; a request sampled at the same edge as the write to its block is judged with the old key.
- R9: A load of the running key follows the same rule: a request sampled at the load edge is judged with the old running key.
- R10: A key write changes only the block it names; the keys of all other blocks keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kwr_en_i | input | 1 | Key store write enable |
| kwr_idx_i | input | 5 | Block number to write |
| kwr_key_i | input | 4 | Key value to store |
| cur_ld_i | input | 1 | Load enable for the running key |
| cur_key_i | input | 4 | New running key |
| req_valid_i | input | 1 | Reference valid |
| req_addr_i | input | 16 | Physical byte address |
| req_priv_i | input | 1 | Reference issued in privileged mode |
| grant_o | output | 1 | Reference allowed (registered) |
| viol_o | output | 1 | Protection violation (registered) |

## Verification
A key write and a request can fall in the same cycle, as can a running-key load and a request. The bench provokes each by driving the write (or the load) and a request to the very block being rewritten on the same clock edge. It expects the decision made with the old value, and it expects the opposite outcome from a repeat of the request on the next cycle. A write to one block beside requests to a neighbouring block shows that the update stays confined to the block it names.

// File: rtl/key_prot_pkg.sv
package key_prot_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned OFF_W_DEF  = 11;
  localparam int unsigned KEY_W_DEF  = 4;
endpackage

// File: rtl/key_prot_store.sv
module key_prot_store #(
  parameter int unsigned NUM_BLK = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned KEY_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [KEY_W-1:0] rd_key_o
);
  logic [KEY_W-1:0] key_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     key_q[b] <= '0;
      else if (hit_wr) key_q[b] <= wr_key_i;
    end
  end

  // read returns the value held before any same-edge write
  assign rd_key_o = key_q[rd_idx_i];
endmodule

// File: rtl/key_prot_cmp.sv
module key_prot_cmp #(
  parameter int unsigned KEY_W = 4
) (
  input  logic             valid_i,
  input  logic             priv_i,
  input  logic [KEY_W-1:0] blk_key_i,
  input  logic [KEY_W-1:0] cur_key_i,
  output logic             grant_o,
  output logic             viol_o
);
  logic match;
  always_comb begin
    match   = (blk_key_i == cur_key_i);
    grant_o = valid_i && (priv_i || match);
    viol_o  = valid_i && !priv_i && !match;
  end
endmodule

// File: rtl/key_prot_chk.sv
module key_prot_chk
  import key_prot_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned OFF_W   = OFF_W_DEF,
  parameter int unsigned KEY_W   = KEY_W_DEF,
  localparam int unsigned IDX_W   = ADDR_W - OFF_W,
  localparam int unsigned NUM_BLK = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kwr_en_i,
  input  logic [IDX_W-1:0]  kwr_idx_i,
  input  logic [KEY_W-1:0]  kwr_key_i,
  input  logic              cur_ld_i,
  input  logic [KEY_W-1:0]  cur_key_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_priv_i,
  output logic              grant_o,
  output logic              viol_o
);
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] unused_off;
  logic [KEY_W-1:0] blk_key;
  logic [KEY_W-1:0] cur_key_q;
  logic             grant_d, viol_d;

  assign req_idx    = req_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = req_addr_i[OFF_W-1:0];

  key_prot_store #(
    .NUM_BLK (NUM_BLK),
    .IDX_W   (IDX_W),
    .KEY_W   (KEY_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (kwr_en_i),
    .wr_idx_i (kwr_idx_i),
    .wr_key_i (kwr_key_i),
    .rd_idx_i (req_idx),
    .rd_key_o (blk_key)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_key_q <= '0;
    else if (cur_ld_i) cur_key_q <= cur_key_i;
  end

  key_prot_cmp #(.KEY_W(KEY_W)) u_cmp (
    .valid_i   (req_valid_i),
    .priv_i    (req_priv_i),
    .blk_key_i (blk_key),
    .cur_key_i (cur_key_q),
    .grant_o   (grant_d),
    .viol_o    (viol_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      viol_o  <= 1'b0;
    end else begin
      grant_o <= grant_d;
      viol_o  <= viol_d;
    end
  end
endmodule

// File: rtl/key_prot_chk_sva.sv
module key_prot_chk_sva #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned KEY_W  = 4,
  localparam int unsigned IDX_W   = ADDR_W - OFF_W,
  localparam int unsigned NUM_BLK = 1 << IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              kwr_en_i,
  input logic [IDX_W-1:0]  kwr_idx_i,
  input logic [KEY_W-1:0]  kwr_key_i,
  input logic              cur_ld_i,
  input logic [KEY_W-1:0]  cur_key_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_priv_i,
  input logic              grant_o,
  input logic              viol_o
);
  // independent shadow of the key state, built from the ports
  logic [KEY_W-1:0] shadow_key [NUM_BLK];
  logic [KEY_W-1:0] shadow_cur;
  logic             exp_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLK; i++) shadow_key[i] <= '0;
      shadow_cur <= '0;
    end else begin
      if (kwr_en_i) shadow_key[kwr_idx_i] <= kwr_key_i;
      if (cur_ld_i) shadow_cur <= cur_key_i;
    end
  end

  assign exp_match = (shadow_key[req_addr_i[ADDR_W-1:OFF_W]] == shadow_cur);

  // R7
  out_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, viol_o}));

  // R7
  answer_given_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (grant_o || viol_o));

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!grant_o && !viol_o));

  // R5
  priv_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_priv_i) |=> grant_o);

  // R3
  match_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_priv_i && exp_match) |=> grant_o);

  // R4
  mismatch_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_priv_i && !exp_match) |=> viol_o);
endmodule

bind key_prot_chk key_prot_chk_sva #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .KEY_W  (KEY_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .kwr_en_i    (kwr_en_i),
  .kwr_idx_i   (kwr_idx_i),
  .kwr_key_i   (kwr_key_i),
  .cur_ld_i    (cur_ld_i),
  .cur_key_i   (cur_key_i),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .req_priv_i  (req_priv_i),
  .grant_o     (grant_o),
  .viol_o      (viol_o)
);

// File: tb/key_prot_chk_test.sv
`timescale 1ns/1ps
module key_prot_chk_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        kwr_en_i = 1'b0;
  logic [4:0]  kwr_idx_i = '0;
  logic [3:0]  kwr_key_i = '0;
  logic        cur_ld_i = 1'b0;
  logic [3:0]  cur_key_i = '0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic        req_priv_i = 1'b0;
  logic        grant_o, viol_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  key_prot_chk uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .kwr_en_i(kwr_en_i), .kwr_idx_i(kwr_idx_i), .kwr_key_i(kwr_key_i),
    .cur_ld_i(cur_ld_i), .cur_key_i(cur_key_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_priv_i(req_priv_i),
    .grant_o(grant_o), .viol_o(viol_o)
  );

  // {addr, priv, running key, expected grant}; block b holds key b[3:0]
  localparam logic [21:0] VEC [12] = '{
    {16'h0000, 1'b0, 4'd0,  1'b1},
    {16'h07FF, 1'b0, 4'd0,  1'b1},
    {16'h0800, 1'b0, 4'd0,  1'b0},
    {16'h0800, 1'b0, 4'd1,  1'b1},
    {16'h8FFF, 1'b0, 4'd1,  1'b1},
    {16'h8000, 1'b0, 4'd1,  1'b0},
    {16'hFFFF, 1'b0, 4'd15, 1'b1},
    {16'hF800, 1'b0, 4'd14, 1'b0},
    {16'h7800, 1'b1, 4'd3,  1'b1},
    {16'h1000, 1'b0, 4'd2,  1'b1},
    {16'h5000, 1'b0, 4'd9,  1'b0},
    {16'h5000, 1'b1, 4'd9,  1'b1}
  };

  task automatic check(input string req, input logic exp_g);
    logic exp_v;
    exp_v = !exp_g;
    n_chk++;
    if (grant_o !== exp_g || viol_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: grant/viol=%b%b expected %b%b", req, grant_o, viol_o, exp_g, exp_v);
    end
  endtask

  task automatic wr_key(input logic [4:0] idx, input logic [3:0] key);
    kwr_en_i = 1'b1; kwr_idx_i = idx; kwr_key_i = key;
    @(posedge clk_i); @(negedge clk_i);
    kwr_en_i = 1'b0;
  endtask

  task automatic ld_cur(input logic [3:0] key);
    cur_ld_i = 1'b1; cur_key_i = key;
    @(posedge clk_i); @(negedge clk_i);
    cur_ld_i = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic p, input string req, input logic exp_g);
    req_valid_i = 1'b1; req_addr_i = a; req_priv_i = p;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0; req_priv_i = 1'b0;
    check(req, exp_g);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    n_chk++;
    if (grant_o !== 1'b0 || viol_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset grant/viol=%b%b expected 00", grant_o, viol_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(16'hA123, 1'b0, "R1 all keys zero", 1'b1);
    ld_cur(4'd5);
    access(16'hA123, 1'b0, "R1 running key 5 vs reset key", 1'b0);
    // R6 idle cycle
    @(negedge clk_i);
    n_chk++;
    if (grant_o !== 1'b0 || viol_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R6: idle grant/viol=%b%b expected 00", grant_o, viol_o);
    end

    // load block keys: block b gets b[3:0]
    for (int b = 0; b < 32; b++) wr_key(5'(b), 4'(b));

    // R2 R3 R4 R5 R7 table
    for (int i = 0; i < 12; i++) begin
      ld_cur(VEC[i][4:1]);
      access(VEC[i][21:6], VEC[i][5], $sformatf("R2/R3/R4/R5 vec %0d", i), VEC[i][0]);
    end

    // R8 write and request to block 3 on the same edge
    ld_cur(4'd3);
    kwr_en_i = 1'b1; kwr_idx_i = 5'd3; kwr_key_i = 4'd7;
    req_valid_i = 1'b1; req_addr_i = 16'h1C40;
    @(posedge clk_i); @(negedge clk_i);
    kwr_en_i = 1'b0; req_valid_i = 1'b0;
    check("R8 same-edge write uses old key", 1'b1);
    access(16'h1C40, 1'b0, "R8 next request sees new key", 1'b0);

    // R9 running-key load and request on the same edge
    ld_cur(4'd7);
    cur_ld_i = 1'b1; cur_key_i = 4'd2;
    req_valid_i = 1'b1; req_addr_i = 16'h1800;
    @(posedge clk_i); @(negedge clk_i);
    cur_ld_i = 1'b0; req_valid_i = 1'b0;
    check("R9 same-edge load uses old running key", 1'b1);
    access(16'h1800, 1'b0, "R9 next request sees new running key", 1'b0);

    // R10 write block 4, neighbour block 5 unchanged
    wr_key(5'd4, 4'd9);
    ld_cur(4'd5);
    access(16'h2800, 1'b0, "R10 block 5 keeps key 5", 1'b1);
    access(16'h2000, 1'b0, "R10 block 4 changed", 1'b0);
    ld_cur(4'd9);
    access(16'h27FF, 1'b0, "R10 block 4 holds key 9", 1'b1);

    // R7 back-to-back requests, one answer each
    req_valid_i = 1'b1; req_addr_i = 16'h2000;
    @(posedge clk_i); @(negedge clk_i);
    check("R7 first of pair", 1'b1);
    req_addr_i = 16'h2800;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R7 second of pair", 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule